// File: doc/BRIEF.md
# Excepting Signed Left Shifter

This functional-unit datapath shifts a signed operand toward its most significant end by an unsigned bit count and fills the vacated low bits with zeros. It detects signed overflow: overflow means the sign bit would change at any single-bit step of the shift, not only in the final value. When overflow occurs, the block does not wrap, saturate or trap. It replaces the numeric result with a poisoned not-a-result value whose reason field carries an overflow code.

The shift count comes from one of two places: an immediate field, or a second operand in the two-input form. Each operand carries its own poison tag and reason code. The operation is speculable. A poisoned input travels to the output with its reason intact, and this stage raises nothing.

The result, its poison tag and reason, and the zero, negative and overflow flags appear after one registered stage.

Top module: `shl_exc_top`

## Requirements
- R1: With an effective count c below DATA_W and no poison or overflow, `res_o` equals `opnd_i` shifted left by c with zero fill, and `nar_o` is 0.
- R2: When `cnt_sel_i` is 0, the count is `cnt_imm_i`, read as unsigned. When `cnt_sel_i` is 1, the count is the full `cnt_opnd_i` word, read as unsigned.
- R3: Overflow is flagged when any of the top c+1 bits of the operand differs from its sign bit. On overflow the outputs are `nar_o`=1, `rsn_o`=OVF_CODE (default 4'h1), `res_o`=0 and `of_o`=1.
- R4: When the count is DATA_W or more, the numeric result is 0. Overflow is flagged exactly when the operand is nonzero.
- R5: A count of zero returns the operand unchanged and never flags overflow.
- R6: A poisoned operand (`opnd_nar_i`=1) gives `nar_o`=1, `rsn_o`=`opnd_rsn_i`, `res_o`=0 and `of_o`=0. A poisoned count operand that is selected does the same with `cnt_rsn_i`. When both are poisoned, the operand's reason wins.
- R7: `zf_o` is 1 when the numeric result is zero, and `nf_o` equals result bit DATA_W-1. Both flags are 0 whenever `nar_o` is 1.
- R8: `valid_o` equals `valid_i` of the previous clock cycle. Reset drives `valid_o` and all data outputs to 0.
- R9: When `cnt_sel_i` is 0, the poison tag and value of `cnt_opnd_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| opnd_i | input | DATA_W | Signed operand |
| opnd_nar_i | input | 1 | Operand poison tag |
| opnd_rsn_i | input | RSN_W | Operand poison reason |
| cnt_sel_i | input | 1 | Count source: 0 immediate, 1 operand |
| cnt_imm_i | input | IMM_W | Immediate count |
| cnt_opnd_i | input | DATA_W | Count operand |
| cnt_nar_i | input | 1 | Count operand poison tag |
| cnt_rsn_i | input | RSN_W | Count operand poison reason |
| valid_o | output | 1 | Result strobe |
| res_o | output | DATA_W | Result word |
| nar_o | output | 1 | Result poison tag |
| rsn_o | output | RSN_W | Result poison reason |
| zf_o | output | 1 | Zero flag |
| nf_o | output | 1 | Negative flag |
| of_o | output | 1 | Overflow flag |

## Verification
The block has one register stage, so every internal fault shows up in the cycle right after the input strobe. A miswired barrel stage gives a wrong `res_o` only for counts that have that stage's bit set, so the stimulus covers single-bit, multi-bit and out-of-range counts. A wrong overflow mask gives a false or missing poison only near the sign boundary. The counts that expose it are the ones where exactly one bit crosses that boundary, such as 0x40000000 shifted by 1 and 0xC0000000 shifted by 1. A fault in the poison priority shows up as a wrong `rsn_o` only when both tags are set or when the unselected count is poisoned.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef enum logic {
    CNT_IMM  = 1'b0,
    CNT_OPND = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/shl_count_sel.sv
module shl_count_sel
  import shl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  localparam int CW    = $clog2(DATA_W) + 1
) (
  input  cnt_src_e          src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [CW-1:0]     cnt_o,
  output logic              big_o
);
  logic [63:0] raw;

  always_comb begin
    raw   = (src_i == CNT_OPND) ? 64'(opnd_i) : 64'(imm_i);
    big_o = raw >= 64'(DATA_W);
    // clamp: every count >= DATA_W behaves the same
    cnt_o = big_o ? CW'(DATA_W) : raw[CW-1:0];
  end
endmodule

// File: rtl/shl_barrel.sv
module shl_barrel #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CW    = SH_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = cnt_i[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  // top count bit set only for clamped count == DATA_W
  assign data_o = cnt_i[CW-1] ? '0 : stg[SH_W];
endmodule

// File: rtl/shl_ovf_chk.sv
module shl_ovf_chk #(
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              big_i,
  output logic              ovf_o
);
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] mask;

  always_comb begin
    diff = data_i ^ {DATA_W{data_i[DATA_W-1]}};
    // bits DATA_W-2 down to DATA_W-1-cnt: those crossing the sign position
    mask = (~({DATA_W{1'b1}} >> cnt_i)) >> 1;
    ovf_o = big_i ? (|data_i) : (|(diff & mask));
  end
endmodule

// File: rtl/shl_flags.sv
module shl_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              nar_i,
  output logic              zf_o,
  output logic              nf_o
);
  assign zf_o = ~nar_i & (res_i == '0);
  assign nf_o = ~nar_i & res_i[DATA_W-1];
endmodule

// File: rtl/shl_exc_top.sv
module shl_exc_top
  import shl_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              IMM_W    = 8,
  parameter int              RSN_W    = 4,
  parameter logic [RSN_W-1:0] OVF_CODE = 4'h1,
  localparam int             CW       = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              opnd_nar_i,
  input  logic [RSN_W-1:0]  opnd_rsn_i,
  input  logic              cnt_sel_i,
  input  logic [IMM_W-1:0]  cnt_imm_i,
  input  logic [DATA_W-1:0] cnt_opnd_i,
  input  logic              cnt_nar_i,
  input  logic [RSN_W-1:0]  cnt_rsn_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              nar_o,
  output logic [RSN_W-1:0]  rsn_o,
  output logic              zf_o,
  output logic              nf_o,
  output logic              of_o
);
  cnt_src_e          src;
  logic [CW-1:0]     cnt;
  logic              big;
  logic [DATA_W-1:0] shifted;
  logic              ovf;
  logic [DATA_W-1:0] res_d;
  logic              nar_d;
  logic [RSN_W-1:0]  rsn_d;
  logic              of_d;
  logic              zf_d;
  logic              nf_d;

  assign src = cnt_src_e'(cnt_sel_i);

  shl_count_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cnt (
    .src_i (src),
    .imm_i (cnt_imm_i),
    .opnd_i(cnt_opnd_i),
    .cnt_o (cnt),
    .big_o (big)
  );

  shl_barrel #(.DATA_W(DATA_W)) u_bsh (
    .data_i(opnd_i),
    .cnt_i (cnt),
    .data_o(shifted)
  );

  shl_ovf_chk #(.DATA_W(DATA_W)) u_ovf (
    .data_i(opnd_i),
    .cnt_i (cnt),
    .big_i (big),
    .ovf_o (ovf)
  );

  // poison priority: operand, selected count operand, own overflow
  always_comb begin
    res_d = shifted;
    nar_d = 1'b0;
    rsn_d = '0;
    of_d  = 1'b0;
    if (opnd_nar_i) begin
      res_d = '0;
      nar_d = 1'b1;
      rsn_d = opnd_rsn_i;
    end else if (src == CNT_OPND && cnt_nar_i) begin
      res_d = '0;
      nar_d = 1'b1;
      rsn_d = cnt_rsn_i;
    end else if (ovf) begin
      res_d = '0;
      nar_d = 1'b1;
      rsn_d = OVF_CODE;
      of_d  = 1'b1;
    end
  end

  shl_flags #(.DATA_W(DATA_W)) u_flg (
    .res_i(res_d),
    .nar_i(nar_d),
    .zf_o (zf_d),
    .nf_o (nf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      nar_o <= 1'b0;
      rsn_o <= '0;
      zf_o  <= 1'b0;
      nf_o  <= 1'b0;
      of_o  <= 1'b0;
    end else if (valid_i) begin
      res_o <= res_d;
      nar_o <= nar_d;
      rsn_o <= rsn_d;
      zf_o  <= zf_d;
      nf_o  <= nf_d;
      of_o  <= of_d;
    end
  end

  a_r8_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !opnd_nar_i && !cnt_sel_i && cnt_imm_i == '0)
    |=> (res_o == $past(opnd_i) && !nar_o && !of_o));

  a_r4_big_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !opnd_nar_i && !cnt_sel_i && 64'(cnt_imm_i) >= 64'(DATA_W))
    |=> (res_o == '0 && (of_o == ($past(opnd_i) != '0))));

  a_r6_poison_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opnd_nar_i)
    |=> (nar_o && rsn_o == $past(opnd_rsn_i) && !of_o && res_o == '0));

  a_r3_ovf_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && of_o) |-> (nar_o && rsn_o == OVF_CODE && res_o == '0));

  a_r7_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && nar_o) |-> (!zf_o && !nf_o));
endmodule

// File: tb/tb_shl_exc_top.sv
module tb_shl_exc_top;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 32;
  localparam int IMM_W = 8;
  localparam int RSN_W = 4;
  localparam logic [RSN_W-1:0] OVF = 4'h1;
  localparam int EXP_W = W + RSN_W + 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] opnd_i = '0;
  logic opnd_nar_i = 1'b0;
  logic [RSN_W-1:0] opnd_rsn_i = '0;
  logic cnt_sel_i = 1'b0;
  logic [IMM_W-1:0] cnt_imm_i = '0;
  logic [W-1:0] cnt_opnd_i = '0;
  logic cnt_nar_i = 1'b0;
  logic [RSN_W-1:0] cnt_rsn_i = '0;
  logic valid_o;
  logic [W-1:0] res_o;
  logic nar_o;
  logic [RSN_W-1:0] rsn_o;
  logic zf_o, nf_o, of_o;

  int checks = 0;
  int fails = 0;
  logic [EXP_W-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shl_exc_top #(.DATA_W(W), .IMM_W(IMM_W), .RSN_W(RSN_W), .OVF_CODE(OVF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .opnd_i(opnd_i), .opnd_nar_i(opnd_nar_i), .opnd_rsn_i(opnd_rsn_i),
    .cnt_sel_i(cnt_sel_i), .cnt_imm_i(cnt_imm_i), .cnt_opnd_i(cnt_opnd_i),
    .cnt_nar_i(cnt_nar_i), .cnt_rsn_i(cnt_rsn_i),
    .valid_o(valid_o), .res_o(res_o), .nar_o(nar_o), .rsn_o(rsn_o),
    .zf_o(zf_o), .nf_o(nf_o), .of_o(of_o)
  );

  // stepwise reference: one bit per step, sign compared before and after
  function automatic logic [EXP_W-1:0] model(
    input logic [W-1:0] x, input logic xn, input logic [RSN_W-1:0] xr,
    input logic sel, input logic [IMM_W-1:0] imm,
    input logic [W-1:0] cop, input logic cn, input logic [RSN_W-1:0] cr);
    logic [W-1:0] v;
    logic ovf, nar, of, zf, nf;
    logic [RSN_W-1:0] r;
    longint unsigned c;
    c = sel ? longint'(cop) : longint'(imm);
    if (c > W) c = W;
    v = x;
    ovf = 1'b0;
    for (int i = 0; i < int'(c); i++) begin
      if (v[W-1] != v[W-2]) ovf = 1'b1;
      v = v << 1;
    end
    nar = 1'b0; of = 1'b0; r = '0;
    if (xn) begin nar = 1'b1; r = xr; end
    else if (sel && cn) begin nar = 1'b1; r = cr; end
    else if (ovf) begin nar = 1'b1; r = OVF; of = 1'b1; end
    if (nar) v = '0;
    zf = !nar && (v == '0);
    nf = !nar && v[W-1];
    return {of, nf, zf, nar, r, v};
  endfunction

  task automatic check(input string tag, input logic [EXP_W-1:0] act, input logic [EXP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [W-1:0] x, input logic xn,
                       input logic [RSN_W-1:0] xr, input logic sel,
                       input logic [IMM_W-1:0] imm, input logic [W-1:0] cop,
                       input logic cn, input logic [RSN_W-1:0] cr);
    @(negedge clk);
    valid_i = 1'b1;
    opnd_i = x; opnd_nar_i = xn; opnd_rsn_i = xr;
    cnt_sel_i = sel; cnt_imm_i = imm; cnt_opnd_i = cop;
    cnt_nar_i = cn; cnt_rsn_i = cr;
    exp_q.push_back(model(x, xn, xr, sel, imm, cop, cn, cr));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      opnd_i = 32'hDEAD_BEEF;
      cnt_imm_i = 8'd3;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 actual=valid_o high expected=no pending item");
      end else begin
        check(tag_q.pop_front(), {of_o, nf_o, zf_o, nar_o, rsn_o, res_o}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", {valid_o, of_o, nf_o, zf_o, nar_o, rsn_o, res_o}, '0);
    rst_ni = 1'b1;
    idle(2);
    // R1 basic shifts
    drive("R1 1<<4",          32'h1, 0, 0, 0, 8'd4, 0, 0, 0);
    drive("R1 1<<30",         32'h1, 0, 0, 0, 8'd30, 0, 0, 0);
    drive("R1 -1<<31 neg",    32'hFFFF_FFFF, 0, 0, 0, 8'd31, 0, 0, 0);
    drive("R1 C0000000<<1",   32'hC000_0000, 0, 0, 0, 8'd1, 0, 0, 0);
    idle(1);
    // R3 overflow
    drive("R3 1<<31",         32'h1, 0, 0, 0, 8'd31, 0, 0, 0);
    drive("R3 40000000<<1",   32'h4000_0000, 0, 0, 0, 8'd1, 0, 0, 0);
    drive("R3 -2<<31",        32'hFFFF_FFFE, 0, 0, 0, 8'd31, 0, 0, 0);
    drive("R3 mid step",      32'h0010_0000, 0, 0, 0, 8'd12, 0, 0, 0);
    // R5 zero count
    drive("R5 count 0",       32'h8234_5678, 0, 0, 0, 8'd0, 0, 0, 0);
    // R4 large counts
    drive("R4 0<<200 zero",   32'h0, 0, 0, 0, 8'd200, 0, 0, 0);
    drive("R4 5<<32",         32'h5, 0, 0, 0, 8'd32, 0, 0, 0);
    drive("R4 -1<<40",        32'hFFFF_FFFF, 0, 0, 0, 8'd40, 0, 0, 0);
    idle(2);
    // R2 count operand
    drive("R2 opnd cnt 3",    32'hFFFF_FFFD, 0, 0, 1, 8'd0, 32'd3, 0, 0);
    drive("R2 opnd cnt huge", 32'h0, 0, 0, 1, 8'd1, 32'h8000_0003, 0, 0);
    drive("R2 opnd cnt huge ovf", 32'h7, 0, 0, 1, 8'd0, 32'h8000_0003, 0, 0);
    drive("R2 imm ignores opnd", 32'h3, 0, 0, 0, 8'd2, 32'd31, 0, 0);
    // R6 poison
    drive("R6 opnd poison",   32'h1, 1, 4'h5, 0, 8'd31, 0, 0, 0);
    drive("R6 cnt poison",    32'h2, 0, 0, 1, 8'd0, 32'd1, 1, 4'h9);
    drive("R6 both poison",   32'h2, 1, 4'h7, 1, 8'd0, 32'd1, 1, 4'h9);
    // R9 unselected count poison
    drive("R9 unsel cnt poison", 32'h2, 0, 0, 0, 8'd3, 32'd1, 1, 4'h9);
    // R7 flags
    drive("R7 zero flag",     32'h8000_0000, 0, 0, 1, 8'd0, 32'd0, 0, 0);
    idle(3);
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);
    check("R8 valid low when idle", {31'd0, valid_o}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule